// File: doc/BRIEF.md
# Boundary-Scan Register with Signature, Pattern and Count Functions

This block is the data-pin boundary register of a test-access controller. It holds exactly one scan cell per data pin: a group of input cells watches the data-input pins and a group of output cells stands behind the data-output pins. All cells run on the test clock. An external TAP state machine supplies capture, shift and update strobes, a Run-Test/Idle indicator and a two-bit test-function select. The block returns the serial test data output and the values that take over the output pins.

Used plainly, the register takes a snapshot of the pins without disturbing normal data flow. It shifts that snapshot out while new values shift in, and it loads the shifted values into output latches. Three test functions reuse the same cells while the TAP sits in Run-Test/Idle. Signature compression folds the input pins into the input cells. Pattern generation steps the output cells as a pseudo-random sequence and drives it onto the pins. Count mode drives a binary up-count onto the output pins, which suits memory addressing, and compresses the input pins at the same time. The interface carries no data stream, so every pin is a plain control or data level and none has back-pressure.

Top module: `bscan_sigpat`

## Requirements
- R1: With trst_n low, all cells and output latches are zero. Whenever test_mode is low, pin_out equals sys_out, whatever the cells hold.
- R2: On a rising tck with capture_dr high, the input cells load pin_in and the output cells load sys_out. Capture has priority over shift and over any test function.
- R3: On a rising tck with shift_dr high and capture_dr low, the chain moves one place: tdi enters output cell W-1, output cell 0 feeds input cell W-1, and tdo shows input cell 0. A word shifted LSB first therefore ends with its low W bits in the input cells and its high W bits in the output cells.
- R4: On a falling tck with update_dr high, the output latches load the output cells. While test_mode is high, pin_out shows the latches.
- R5: With func_sel = 1 (signature), each tick replaces the input cells s with step(s) XOR pin_in, and the output cells hold. A tick is a rising tck with run_idle high and both capture_dr and shift_dr low. step(s) = {s[W-2:0], fb}, where fb is the XOR of the bits of s selected by the maximal-length tap mask; for W = 8 that mask is 8'hB8 (bits 7, 5, 4, 3).
- R6: With func_sel = 2 (pattern), each tick replaces the output cells with step(s), or with 1 when they hold 0, and the input cells hold.
- R7: With func_sel = 3 (count), each tick adds one to the output cells, wrapping at all ones. In the same tick the input cells compress pin_in as in R5.
- R8: With func_sel = 2 or 3, the output latches load the output cells on every falling tck, so the sequence reaches pin_out while test_mode is high.
- R9: Without a tick, and with func_sel = 0 (plain) even with run_idle high, no cell changes except through capture or shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| test_mode | input | 1 | Output latches take over the output pins |
| capture_dr | input | 1 | Capture strobe from the TAP |
| shift_dr | input | 1 | Shift strobe from the TAP |
| update_dr | input | 1 | Update strobe, acted on at the falling edge |
| run_idle | input | 1 | TAP is in Run-Test/Idle |
| func_sel | input | 2 | 0 plain, 1 signature, 2 pattern, 3 count |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out |
| pin_in | input | W | Values on the data-input pins |
| sys_out | input | W | Values functional logic drives to the output pins |
| pin_out | output | W | Values reaching the output pins |

## Verification
The input and output groups are captured with different values, 8'hA5 on the inputs and 8'h3C on the outputs. A group swap or a bit reversal in the chain then shows up in the word read out serially. Signature runs use a varying pin sequence, and a later hold phase changes the pins with run_idle low, which separates a correct XOR fold from one that ignores the pins or advances outside Run-Test/Idle. Pattern generation starts from a zero seed to exercise the zero-to-one replacement and the first steps of the sequence. Count mode starts at 8'hFE so that the wrap to zero is seen on the pins while the inputs are compressed.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic [1:0] {
    TF_PLAIN = 2'd0,
    TF_SIG   = 2'd1,
    TF_PAT   = 2'd2,
    TF_CNT   = 2'd3
  } tf_mode_e;

  // Maximal-length tap mask for a left-shifting LFSR of width w.
  function automatic logic [31:0] lfsr_mask(input int w);
    case (w)
      2:       return 32'h3;
      3:       return 32'h6;
      4:       return 32'hC;
      5:       return 32'h14;
      6:       return 32'h30;
      7:       return 32'h60;
      16:      return 32'hB400;
      default: return 32'hB8;
    endcase
  endfunction
endpackage

// File: rtl/bsc_in_group.sv
module bsc_in_group import bsc_pkg::*; #(
  parameter int W = 8
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         capture,
  input  logic         shift,
  input  logic         tick,
  input  logic         sig_en,
  input  logic [W-1:0] pin_in,
  input  logic         ser_in,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TAPS = W'(lfsr_mask(W));

  logic fb;
  assign fb = ^(q & TAPS);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)            q <= '0;
    else if (capture)       q <= pin_in;
    else if (shift)         q <= {ser_in, q[W-1:1]};
    else if (tick && sig_en) q <= {q[W-2:0], fb} ^ pin_in;
  end
endmodule

// File: rtl/bsc_out_group.sv
module bsc_out_group import bsc_pkg::*; #(
  parameter int W = 8
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         capture,
  input  logic         shift,
  input  logic         tick,
  input  tf_mode_e     mode,
  input  logic [W-1:0] sys_out,
  input  logic         ser_in,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TAPS = W'(lfsr_mask(W));
  localparam logic [W-1:0] ONE  = W'(1);

  logic         fb;
  logic [W-1:0] nxt;
  assign fb = ^(q & TAPS);

  always_comb begin
    nxt = q;
    case (mode)
      TF_PAT:  nxt = (q == '0) ? ONE : {q[W-2:0], fb};
      TF_CNT:  nxt = q + ONE;
      default: nxt = q;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)      q <= '0;
    else if (capture) q <= sys_out;
    else if (shift)   q <= {ser_in, q[W-1:1]};
    else if (tick)    q <= nxt;
  end
endmodule

// File: rtl/bsc_out_latch.sv
module bsc_out_latch #(
  parameter int W = 8
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)   q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/bscan_sigpat.sv
module bscan_sigpat import bsc_pkg::*; #(
  parameter int W = 8
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         test_mode,
  input  logic         capture_dr,
  input  logic         shift_dr,
  input  logic         update_dr,
  input  logic         run_idle,
  input  logic [1:0]   func_sel,
  input  logic         tdi,
  output logic         tdo,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] sys_out,
  output logic [W-1:0] pin_out
);
  tf_mode_e     mode;
  logic         tick, sig_en, auto_load;
  logic [W-1:0] in_q, out_q, lat_q;

  assign mode      = tf_mode_e'(func_sel);
  assign tick      = run_idle && !capture_dr && !shift_dr;
  assign sig_en    = (mode == TF_SIG) || (mode == TF_CNT);
  assign auto_load = (mode == TF_PAT) || (mode == TF_CNT);

  bsc_out_group #(.W(W)) u_out (
    .tck(tck), .trst_n(trst_n), .capture(capture_dr), .shift(shift_dr),
    .tick(tick), .mode(mode), .sys_out(sys_out), .ser_in(tdi), .q(out_q)
  );

  bsc_in_group #(.W(W)) u_in (
    .tck(tck), .trst_n(trst_n), .capture(capture_dr), .shift(shift_dr),
    .tick(tick), .sig_en(sig_en), .pin_in(pin_in), .ser_in(out_q[0]),
    .q(in_q)
  );

  bsc_out_latch #(.W(W)) u_lat (
    .tck(tck), .trst_n(trst_n), .load(update_dr || auto_load),
    .d(out_q), .q(lat_q)
  );

  assign tdo     = in_q[0];
  assign pin_out = test_mode ? lat_q : sys_out;
endmodule

// File: rtl/bscan_sigpat_chk.sv
module bscan_sigpat_chk #(
  parameter int W = 8
) (
  input logic         tck,
  input logic         trst_n,
  input logic         capture_dr,
  input logic         shift_dr,
  input logic         run_idle,
  input logic [1:0]   func_sel,
  input logic [W-1:0] pin_in,
  input logic [W-1:0] sys_out,
  input logic [W-1:0] in_q,
  input logic [W-1:0] out_q
);
  localparam logic [W-1:0] ONE = W'(1);

  a_r2_capture: assert property (@(posedge tck) disable iff (!trst_n)
    capture_dr |=> (in_q == $past(pin_in)) && (out_q == $past(sys_out)));

  a_r3_chain_link: assert property (@(posedge tck) disable iff (!trst_n)
    (shift_dr && !capture_dr) |=> in_q[W-1] == $past(out_q[0]));

  a_r9_hold: assert property (@(posedge tck) disable iff (!trst_n)
    (!run_idle && !capture_dr && !shift_dr) |=> $stable(in_q) && $stable(out_q));

  a_r6_never_zero: assert property (@(posedge tck) disable iff (!trst_n)
    (run_idle && !capture_dr && !shift_dr && func_sel == 2'd2) |=> out_q != '0);

  a_r7_count_up: assert property (@(posedge tck) disable iff (!trst_n)
    (run_idle && !capture_dr && !shift_dr && func_sel == 2'd3)
      |=> out_q == $past(out_q) + ONE);
endmodule

bind bscan_sigpat bscan_sigpat_chk #(.W(W)) u_chk (
  .tck(tck), .trst_n(trst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
  .run_idle(run_idle), .func_sel(func_sel), .pin_in(pin_in), .sys_out(sys_out),
  .in_q(in_q), .out_q(out_q)
);

// File: tb/bscan_sigpat_tb.sv
module bscan_sigpat_tb;
  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic       test_mode = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0;
  logic       update_dr = 1'b0, run_idle = 1'b0, tdi = 1'b0;
  logic [1:0] func_sel = 2'd0;
  logic [7:0] pin_in = 8'h00, sys_out = 8'h3C;
  logic       tdo;
  logic [7:0] pin_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 tck = ~tck;

  bscan_sigpat #(.W(8)) u_dut (
    .tck(tck), .trst_n(trst_n), .test_mode(test_mode), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .run_idle(run_idle),
    .func_sel(func_sel), .tdi(tdi), .tdo(tdo), .pin_in(pin_in),
    .sys_out(sys_out), .pin_out(pin_out)
  );

  function automatic logic [7:0] stepf(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge tck); #1;
  endtask

  task automatic shift_word(input logic [15:0] din, output logic [15:0] dout);
    shift_dr = 1'b1;
    for (int i = 0; i < 16; i++) begin
      dout[i] = tdo;
      tdi = din[i];
      step();
    end
    shift_dr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pins follow sys_out", {8'h0, pin_out}, 16'h003C);
    chk("R1 tdo zero", {15'h0, tdo}, 16'h0);
    test_mode = 1'b1; #1;
    chk("R1 latches zero", {8'h0, pin_out}, 16'h0000);
    test_mode = 1'b0;
    trst_n = 1'b1;
    step();
  endtask

  task automatic t_capture_shift();
    logic [15:0] got;
    pin_in = 8'hA5; sys_out = 8'h3C;
    capture_dr = 1'b1; step(); capture_dr = 1'b0;
    shift_word(16'h0000, got);
    chk("R2/R3 captured word", got, 16'h3CA5);
  endtask

  task automatic t_update();
    logic [15:0] got;
    shift_word(16'h96C3, got);
    chk("R3 chain empty", got, 16'h0000);
    sys_out = 8'h11;
    update_dr = 1'b1; step(); update_dr = 1'b0;
    chk("R4 test_mode low keeps sys_out", {8'h0, pin_out}, 16'h0011);
    test_mode = 1'b1; #1;
    chk("R4 latch drives pins", {8'h0, pin_out}, 16'h0096);
    test_mode = 1'b0;
  endtask

  task automatic t_plain_idle();
    logic [15:0] got;
    shift_word(16'h4D27, got);
    func_sel = 2'd0; run_idle = 1'b1; pin_in = 8'hFF;
    repeat (3) step();
    run_idle = 1'b0;
    shift_word(16'h0000, got);
    chk("R9 plain mode holds in run_idle", got, 16'h4D27);
  endtask

  task automatic t_signature();
    logic [15:0] got;
    logic [7:0] exp;
    logic [7:0] pats [4] = '{8'h01, 8'h80, 8'h5A, 8'hC3};
    shift_word(16'h775A, got);
    exp = 8'h5A;
    func_sel = 2'd1; run_idle = 1'b1;
    for (int k = 0; k < 4; k++) begin
      pin_in = pats[k];
      step();
      exp = stepf(exp) ^ pats[k];
    end
    run_idle = 1'b0;
    for (int k = 0; k < 3; k++) begin
      pin_in = 8'h10 + 8'(k);
      step();
    end
    func_sel = 2'd0;
    shift_word(16'h0000, got);
    chk("R5 signature", {8'h0, got[7:0]}, {8'h0, exp});
    chk("R5 output cells hold", {8'h0, got[15:8]}, 16'h0077);
    chk("R9 no advance outside run_idle", got, {8'h77, exp});
  endtask

  task automatic t_pattern();
    logic [15:0] got;
    logic [7:0] exp;
    shift_word(16'h00E1, got);
    exp = 8'h00;
    func_sel = 2'd2; test_mode = 1'b1; run_idle = 1'b1;
    for (int k = 0; k < 6; k++) begin
      step(); #5;
      exp = (exp == 8'h00) ? 8'h01 : stepf(exp);
      chk(k == 0 ? "R6 zero seed becomes one" : "R8 pattern on pins",
          {8'h0, pin_out}, {8'h0, exp});
    end
    run_idle = 1'b0;
    step();
    func_sel = 2'd0; test_mode = 1'b0;
    shift_word(16'h0000, got);
    chk("R6 pattern cells and input hold", got, {exp, 8'hE1});
  endtask

  task automatic t_count();
    logic [15:0] got;
    logic [7:0] exp_in, exp_out;
    logic [7:0] pats [3] = '{8'h33, 8'hF0, 8'h0F};
    shift_word(16'hFE00, got);
    exp_in = 8'h00; exp_out = 8'hFE;
    func_sel = 2'd3; test_mode = 1'b1; run_idle = 1'b1;
    for (int k = 0; k < 3; k++) begin
      pin_in = pats[k];
      step(); #5;
      exp_out = exp_out + 8'h01;
      exp_in = stepf(exp_in) ^ pats[k];
      chk("R7 count on pins", {8'h0, pin_out}, {8'h0, exp_out});
    end
    run_idle = 1'b0;
    step();
    func_sel = 2'd0; test_mode = 1'b0;
    shift_word(16'h0000, got);
    chk("R7 count with signature", got, {exp_out, exp_in});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #12;
    t_reset();
    t_capture_shift();
    t_update();
    t_plain_idle();
    t_signature();
    t_pattern();
    t_count();
    finish_run();
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end
endmodule